// File: doc/BRIEF.md
# SD Card Clock Generator and Bus-Width Control

This block produces the card clock for an SD/MMC host controller and holds the data bus width setting. Three small registers are written through a simple single-cycle write port. The clock control register holds a frequency select value, an internal clock enable, a card clock enable and a read-only stable flag. The host control register holds the width bits. The reset register starts a self-clearing soft reset of the other two.

Software brings the clock up in three steps. It first writes a divisor with internal clock enable set. It then polls until the stable flag reads 1, which happens a fixed number of base-clock cycles later. Only then does it set the card clock enable. A frequency select value N of 1 or more gives a card clock of base/(2·N). A value of 0 passes the base clock straight through. A new divisor written while the clock runs is applied only at the end of a full output period, so no high or low phase is ever cut short.

The decoded bus width is driven on its own output for the data path. The soft reset clears both control registers, holds them clear, and then drops its own bit without any further write from software.

Top module: `sd_clock_width_ctrl`

## Requirements
- R1: After the synchronous reset, the clock control readback, the host control readback and the reset readback are all zero, the width output is 1-bit (code 0), and the card clock is low.
- R2: A write with reg_addr 0 loads the clock control register. Readback bits [15:8] are the frequency select, bit 2 is the card clock enable and bit 0 is the internal clock enable. Bit 1 is the stable flag and is read-only: the written value of bit 1 has no effect on the readback.
- R3: The stable flag (clock control bit 1) reads 1 exactly SETTLE_CYCLES clock edges after the edge that writes internal clock enable from 0 to 1, and reads 0 before that.
- R4: The stable flag reads 0 from the same edge that writes internal clock enable to 0, and the card clock stops at that edge.
- R5: sd_clk_o stays low whenever the card clock enable or the stable flag is 0.
- R6: With a frequency select N of 1 or more and the clock running, sd_clk_o is high for N base cycles and then low for N base cycles, repeating.
- R7: With a frequency select of 0 and the clock running, sd_clk_o follows the base clock: high while clk is high and low while clk is low.
- R8: A new frequency select written while the clock runs takes effect only at the end of a low phase, so every completed high or low phase lasts either the old N or the new N.
- R9: A write with reg_addr 1 loads host control bits [7:0], which read back unchanged. bus_width_o is 2 (8-bit) when bit 5 is 1. Otherwise it is 1 (4-bit) when bit 1 is 1, and 0 (1-bit) when bit 1 is 0.
- R10: A write with reg_addr 2 and bit 0 = 1 sets swrst_rd for exactly RST_CYCLES cycles, after which it clears by itself. From the edge of that write, both control registers read 0, and any writes to them while the reset is in progress are ignored. A write with bit 0 = 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; also the clock the divider works from |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 clock control, 1 host control, 2 reset |
| reg_wdata | input | 16 | Write data |
| clk_ctl_rd | output | 16 | Clock control readback including the stable flag |
| host_ctl_rd | output | 8 | Host control readback |
| swrst_rd | output | 1 | Soft reset in progress (reset register bit 0) |
| bus_width_o | output | 2 | Decoded data bus width: 0 = 1-bit, 1 = 4-bit, 2 = 8-bit |
| sd_clk_o | output | 1 | Card clock |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a divisor change and a period boundary. The bench rewrites the frequency select at an arbitrary point while the clock runs and times every completed high and low phase. Each phase must last either the old ratio or the new one. The second pair is the soft reset and register writes. The bench writes host control while the reset is still counting. It then checks that the register stays clear and that the reset bit stays high for exactly its fixed length.

// File: rtl/sdcw_pkg.sv
// Shared encodings for the SD clock / bus-width control block.
// Assumes a 16-bit clock control register with the divisor in the upper byte.
package sdcw_pkg;

    // Register select values on reg_addr
    typedef enum logic [1:0] {
        SEL_CLK  = 2'd0,
        SEL_HOST = 2'd1,
        SEL_RST  = 2'd2
    } reg_sel_e;

    // Decoded data bus width
    typedef enum logic [1:0] {
        BW_1BIT = 2'd0,
        BW_4BIT = 2'd1,
        BW_8BIT = 2'd2
    } bus_width_e;

    // Clock control bit positions (software-visible, kept fixed)
    localparam int CC_INT_EN   = 0;
    localparam int CC_STABLE   = 1;
    localparam int CC_CARD_EN  = 2;
    localparam int CC_FSEL_LSB = 8;

    // Host control width bits
    localparam int HC_WIDE4 = 1;
    localparam int HC_WIDE8 = 5;

    // Reset register bit
    localparam int SR_ALL = 0;

endpackage

// File: rtl/sdcw_regs.sv
// Register bank: clock control, host control and the self-clearing soft reset.
// Assumes single-cycle writes; the soft reset clears and holds both control
// registers for RST_CYCLES cycles, ignoring writes meanwhile.
module sdcw_regs
    import sdcw_pkg::*;
#(
    parameter int FSEL_W     = 8,
    parameter int RST_CYCLES = 8,
    localparam int CC_W      = CC_FSEL_LSB + FSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              stable_i,
    output logic [FSEL_W-1:0] fsel_o,
    output logic              int_en_o,
    output logic              card_en_o,
    output logic [CC_W-1:0]   clk_ctl_rd,
    output logic [7:0]        host_ctl_rd,
    output logic              swrst_rd,
    output logic [1:0]        bus_width_o
);

    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic              busy_q;
    logic [RC_W-1:0]   rcnt_q;
    logic              start_rst;
    logic              hold_clear;
    logic [FSEL_W-1:0] fsel_q;
    logic              int_en_q;
    logic              card_en_q;
    logic [7:0]        host_q;
    bus_width_e        bw;

    // Detect a request to start the soft reset
    always_comb begin
        start_rst = reg_wr && (reg_addr == SEL_RST) && reg_wdata[SR_ALL] && !busy_q;
    end

    assign hold_clear = busy_q || start_rst;

    // Soft reset sequencer: busy for RST_CYCLES cycles then self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rcnt_q <= '0;
        end else if (busy_q) begin
            if (rcnt_q == RC_W'(RST_CYCLES - 1)) begin
                busy_q <= 1'b0;
            end
            rcnt_q <= rcnt_q + 1'b1;
        end else if (start_rst) begin
            busy_q <= 1'b1;
            rcnt_q <= '0;
        end
    end

    // Clock control fields; the stable flag is not stored here
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            fsel_q    <= '0;
            int_en_q  <= 1'b0;
            card_en_q <= 1'b0;
        end else if (reg_wr && (reg_addr == SEL_CLK)) begin
            fsel_q    <= reg_wdata[CC_FSEL_LSB +: FSEL_W];
            int_en_q  <= reg_wdata[CC_INT_EN];
            card_en_q <= reg_wdata[CC_CARD_EN];
        end
    end

    // Host control byte
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            host_q <= '0;
        end else if (reg_wr && (reg_addr == SEL_HOST)) begin
            host_q <= reg_wdata[7:0];
        end
    end

    // Width decode: 8-bit bit wins over the 4-bit bit
    always_comb begin
        if (host_q[HC_WIDE8]) begin
            bw = BW_8BIT;
        end else if (host_q[HC_WIDE4]) begin
            bw = BW_4BIT;
        end else begin
            bw = BW_1BIT;
        end
    end

    // Readback assembly
    always_comb begin
        clk_ctl_rd                          = '0;
        clk_ctl_rd[CC_FSEL_LSB +: FSEL_W]   = fsel_q;
        clk_ctl_rd[CC_CARD_EN]              = card_en_q;
        clk_ctl_rd[CC_STABLE]               = stable_i;
        clk_ctl_rd[CC_INT_EN]               = int_en_q;
    end

    assign host_ctl_rd = host_q;
    assign swrst_rd    = busy_q;
    assign bus_width_o = bw;
    assign fsel_o      = fsel_q;
    assign int_en_o    = int_en_q;
    assign card_en_o   = card_en_q;

endmodule

// File: rtl/sdcw_settle.sv
// Internal clock settle timer: raises the stable flag SETTLE_CYCLES edges after
// the internal clock enable rises; drops it combinationally with the enable.
module sdcw_settle #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_en_i,
    output logic stable_o
);

    localparam int SC_W = $clog2(SETTLE_CYCLES + 1);

    logic [SC_W-1:0] cnt_q;
    logic            done_q;

    // Count settle cycles while enabled, restart whenever the enable is low
    always_ff @(posedge clk) begin
        if (!rst_n || !int_en_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == SC_W'(SETTLE_CYCLES - 1)) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stable_o = done_q && int_en_i;

endmodule

// File: rtl/sdcw_divider.sv
// Card clock divider: field N>=1 gives N high / N low base cycles, N=0 passes
// the base clock through a negative-edge enable latch. A new divisor or a new
// run state is taken only at the end of a low phase; losing run stops at once.
module sdcw_divider #(
    parameter int FSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] fsel_i,
    input  logic              run_i,
    output logic              sd_clk_o
);

    logic [FSEL_W-1:0] cur_q;
    logic [FSEL_W-1:0] cnt_q;
    logic              phase_q;
    logic              gate_q;
    logic              byp_q;
    logic              last_cnt;
    logic              period_end;
    logic              reload;

    // Phase terminal count and period boundary detection
    always_comb begin
        last_cnt   = (cnt_q == (cur_q - FSEL_W'(1)));
        period_end = gate_q && ((cur_q == '0) || (!phase_q && last_cnt));
        reload     = !gate_q || period_end || !run_i;
    end

    // Divider state: reload on boundary or stop, otherwise count the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            gate_q  <= 1'b0;
        end else if (reload) begin
            cur_q   <= fsel_i;
            cnt_q   <= '0;
            gate_q  <= run_i;
            phase_q <= run_i && (fsel_i != '0);
        end else if (last_cnt) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Pass-through enable, changed only while the base clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else begin
            byp_q <= gate_q && (cur_q == '0) && run_i;
        end
    end

    assign sd_clk_o = ((clk && byp_q) || phase_q) && run_i;

endmodule

// File: rtl/sd_clock_width_ctrl.sv
// Top of the SD clock and bus-width control block: register bank, internal
// clock settle timer and card clock divider. The card clock runs only while
// both the card clock enable and the stable flag are set.
module sd_clock_width_ctrl
    import sdcw_pkg::*;
#(
    parameter int FSEL_W        = 8,
    parameter int SETTLE_CYCLES = 16,
    parameter int RST_CYCLES    = 8,
    localparam int CC_W         = CC_FSEL_LSB + FSEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [CC_W-1:0] clk_ctl_rd,
    output logic [7:0]      host_ctl_rd,
    output logic            swrst_rd,
    output logic [1:0]      bus_width_o,
    output logic            sd_clk_o
);

    logic [FSEL_W-1:0] fsel;
    logic              int_en;
    logic              card_en;
    logic              stable;
    logic              run;

    sdcw_regs #(
        .FSEL_W     (FSEL_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .stable_i    (stable),
        .fsel_o      (fsel),
        .int_en_o    (int_en),
        .card_en_o   (card_en),
        .clk_ctl_rd  (clk_ctl_rd),
        .host_ctl_rd (host_ctl_rd),
        .swrst_rd    (swrst_rd),
        .bus_width_o (bus_width_o)
    );

    sdcw_settle #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_en_i (int_en),
        .stable_o (stable)
    );

    // Card clock may run only after the three-step bring-up
    assign run = card_en && stable;

    sdcw_divider #(
        .FSEL_W (FSEL_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsel_i   (fsel),
        .run_i    (run),
        .sd_clk_o (sd_clk_o)
    );

endmodule

// File: rtl/sdcw_checker.sv
// Port-level protocol checks for sd_clock_width_ctrl, attached by bind.
module sdcw_checker
    import sdcw_pkg::*;
#(
    parameter int CC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CC_W-1:0] clk_ctl_rd,
    input logic [7:0]      host_ctl_rd,
    input logic            swrst_rd,
    input logic [1:0]      bus_width_o,
    input logic            sd_clk_o
);

    // R4
    stable_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ctl_rd[CC_STABLE] |-> clk_ctl_rd[CC_INT_EN]);

    // R3
    no_instant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ctl_rd[CC_INT_EN]) |-> !clk_ctl_rd[CC_STABLE]);

    // R5
    card_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_ctl_rd[CC_CARD_EN] || !clk_ctl_rd[CC_STABLE]) |-> !sd_clk_o);

    // R10
    reset_clears_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_rd |-> ((clk_ctl_rd == '0) && (host_ctl_rd == '0)));

    // R9
    width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_width_o != 2'b11) && (host_ctl_rd[HC_WIDE8] -> (bus_width_o == BW_8BIT)));

endmodule

bind sd_clock_width_ctrl sdcw_checker #(.CC_W(CC_W)) u_sdcw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_ctl_rd  (clk_ctl_rd),
    .host_ctl_rd (host_ctl_rd),
    .swrst_rd    (swrst_rd),
    .bus_width_o (bus_width_o),
    .sd_clk_o    (sd_clk_o)
);

// File: tb/tb_sd_clock_width_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random host control
// and divisor values; expectations come from bench functions.
module tb_sd_clock_width_ctrl;

    localparam int SETTLE = 16;
    localparam int RSTC   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] clk_ctl_rd;
    logic [7:0]  host_ctl_rd;
    logic        swrst_rd;
    logic [1:0]  bus_width_o;
    logic        sd_clk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sd_clock_width_ctrl #(
        .FSEL_W        (8),
        .SETTLE_CYCLES (SETTLE),
        .RST_CYCLES    (RSTC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .clk_ctl_rd  (clk_ctl_rd),
        .host_ctl_rd (host_ctl_rd),
        .swrst_rd    (swrst_rd),
        .bus_width_o (bus_width_o),
        .sd_clk_o    (sd_clk_o)
    );

    function automatic logic [1:0] exp_width(input logic [7:0] h);
        if (h[5]) return 2'd2;
        if (h[1]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one register; returns 2 ns after the edge that captured it
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    // Three-step bring-up with divisor n
    task automatic bring_up(input logic [7:0] n);
        wr(2'd0, 16'h0000);
        wr(2'd0, {n, 8'h01});
        for (int i = 0; i < 4 * SETTLE; i++) begin
            if (clk_ctl_rd[1]) break;
            tick();
        end
        wr(2'd0, {n, 8'h05});
    endtask

    // Time completed phases; each must last na or nb samples
    task automatic measure(input int cycles, input int na, input int nb,
                           input string req, output int runs);
        logic prev;
        int   len;
        bit   started;
        runs = 0; started = 0; len = 0;
        tick();
        prev = sd_clk_o;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (sd_clk_o == prev) begin
                len++;
            end else begin
                if (started) begin
                    runs++;
                    check(len == na || len == nb, req, len, na);
                end
                started = 1; len = 1; prev = sd_clk_o;
            end
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int runs;
        int k;
        int hi;
        logic [7:0] h;
        logic [7:0] n;
        void'($urandom(32'h5D1C));

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();

        // R1 reset state
        check(clk_ctl_rd == 16'h0, "R1 clk_ctl", clk_ctl_rd, 0);
        check(host_ctl_rd == 8'h0, "R1 host_ctl", host_ctl_rd, 0);
        check(swrst_rd == 1'b0, "R1 swrst", swrst_rd, 0);
        check(bus_width_o == 2'd0, "R1 width", bus_width_o, 0);
        check(sd_clk_o == 1'b0, "R1 sd_clk", sd_clk_o, 0);

        // R2 layout and read-only stable bit
        wr(2'd0, 16'hA7FF);
        check(clk_ctl_rd == 16'hA705, "R2 layout", clk_ctl_rd, 16'hA705);
        wr(2'd0, 16'h3C02);
        check(clk_ctl_rd == 16'h3C00, "R2 stable read-only", clk_ctl_rd, 16'h3C00);

        // R3 settle timing, R5 card clock held low while settling
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0205);
        k = 0;
        check(clk_ctl_rd[1] == 1'b0, "R3 stable at write", clk_ctl_rd[1], 0);
        while (!clk_ctl_rd[1] && k < 4 * SETTLE) begin
            check(sd_clk_o == 1'b0, "R5 low while settling", sd_clk_o, 0);
            tick();
            k++;
        end
        check(k == SETTLE, "R3 settle cycles", k, SETTLE);

        // R6 directed and random divisors
        foreach (n[i]) begin end
        for (int t = 0; t < 7; t++) begin
            case (t)
                0: n = 8'd1;
                1: n = 8'd2;
                2: n = 8'd3;
                3: n = 8'd5;
                default: n = 8'(1 + ($urandom % 12));
            endcase
            bring_up(n);
            measure(6 * n + 8, n, n, "R6 phase length", runs);
            check(runs >= 4, "R6 phases seen", runs, 4);
        end

        // R5 card enable off: clock stays low
        wr(2'd0, 16'h0301);
        for (int i = 0; i < 10; i++) begin
            tick();
            check(sd_clk_o == 1'b0, "R5 card enable off", sd_clk_o, 0);
        end

        // R7 pass-through
        bring_up(8'd0);
        repeat (2) tick();
        for (int i = 0; i < 8; i++) begin
            tick();
            check(sd_clk_o == 1'b1, "R7 follows clk high", sd_clk_o, 1);
            #4;
            check(sd_clk_o == 1'b0, "R7 follows clk low", sd_clk_o, 0);
        end

        // R8 divisor change mid-period, two directions
        bring_up(8'd3);
        fork
            measure(90, 3, 1, "R8 change 3 to 1", runs);
            begin
                repeat (20 + ($urandom % 5)) @(posedge clk);
                wr(2'd0, 16'h0105);
            end
        join
        check(runs >= 20, "R8 phases seen", runs, 20);
        bring_up(8'd2);
        fork
            measure(90, 2, 5, "R8 change 2 to 5", runs);
            begin
                repeat (17 + ($urandom % 5)) @(posedge clk);
                wr(2'd0, 16'h0505);
            end
        join
        check(runs >= 10, "R8 phases seen", runs, 10);

        // R4 clear internal enable while running
        bring_up(8'd2);
        repeat (3) tick();
        wr(2'd0, 16'h0204);
        check(clk_ctl_rd[1] == 1'b0, "R4 stable cleared", clk_ctl_rd[1], 0);
        for (int i = 0; i < 6; i++) begin
            check(sd_clk_o == 1'b0, "R4 clock stopped", sd_clk_o, 0);
            tick();
        end

        // R9 directed and random width settings
        wr(2'd1, 16'h0022);
        check(bus_width_o == 2'd2, "R9 both bits", bus_width_o, 2);
        wr(2'd1, 16'h0002);
        check(bus_width_o == 2'd1, "R9 4-bit", bus_width_o, 1);
        wr(2'd1, 16'h00DD);
        check(bus_width_o == 2'd0, "R9 other bits only", bus_width_o, 0);
        for (int i = 0; i < 24; i++) begin
            h = 8'($urandom);
            wr(2'd1, {8'h00, h});
            check(host_ctl_rd == h, "R9 readback", host_ctl_rd, h);
            check(bus_width_o == exp_width(h), "R9 decode", bus_width_o, exp_width(h));
        end

        // R10 soft reset with a write during the reset
        wr(2'd2, 16'h0000);
        check(swrst_rd == 1'b0, "R10 zero write no reset", swrst_rd, 0);
        bring_up(8'd1);
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0001);
        check(swrst_rd == 1'b1, "R10 reset starts", swrst_rd, 1);
        check(clk_ctl_rd == 16'h0, "R10 clk_ctl cleared", clk_ctl_rd, 0);
        check(host_ctl_rd == 8'h0, "R10 host_ctl cleared", host_ctl_rd, 0);
        check(sd_clk_o == 1'b0, "R10 clock stopped", sd_clk_o, 0);
        wr(2'd1, 16'h0020);
        check(host_ctl_rd == 8'h0, "R10 write ignored", host_ctl_rd, 0);
        check(bus_width_o == 2'd0, "R10 width unchanged", bus_width_o, 0);
        hi = 2;
        for (int i = 0; i < 4 * RSTC; i++) begin
            tick();
            if (!swrst_rd) break;
            hi++;
        end
        check(hi == RSTC, "R10 reset length", hi, RSTC);
        wr(2'd1, 16'h0020);
        check(bus_width_o == 2'd2, "R10 writes after reset", bus_width_o, 2);

        done = 1;
        summary();
        $finish;
    end

endmodule